// File: doc/BRIEF.md
# Round-Robin Multi-Problem Iteration Sequencer

This block is the control core of an iterative linear-system solver that shares one deep arithmetic pipeline among several independent problems. Time is cut into slots of N+3 cycles. In the first N cycles the shared product unit streams the matrix rows for the matrix-vector product. The last three cycles cover the direction-product dot, the residual-energy dot, and, on a problem's first pass only, the initial residual energy. The pipeline is padded so that one full iteration lasts exactly a whole number P of slots, where P = ceil((7N + 36*ceil(log2 N) + 127) / (N+3)). Each slot index, its tag, therefore always belongs to the same problem, and a result comes back just as its owner's slot opens again.

At the opening cycle of every slot the sequencer reads the feedback energies of the returning problem. It decides whether that problem continues, has converged, or has reached the iteration limit. A slot that is empty, or that is freed in that same cycle, takes in a new problem when one is waiting. The new problem's solution starts at zero, and its direction and residual both start from the right-hand side. The per-cycle operation select, the row index and the first-pass flag steer the datapath. The padding length is given as an output so the datapath can size its delay line.

Top module: `rr_iter_sequencer`

## Requirements
- R1: A slot lasts N+3 cycles and `slot_start` is high only in its first cycle. `slot_tag` steps by one per slot and wraps from P-1 to 0, with P = 33 for the defaults (N=4).
- R2: In an occupied slot, `slot_op` is 1 (row) in cycles 0..N-1 with `row_idx` equal to the cycle number. It is 2 (direction dot) in cycle N and 3 (residual dot) in cycle N+1. In cycle N+2 it is 4 (initial energy) on the problem's first pass and 0 (idle) otherwise. An empty slot shows 0 throughout.
- R3: `pad_len` equals P*(N+3) minus the base loop latency 7N + 36*ceil(log2 N) + 127, a value from 0 to N+2 (4 for the defaults).
- R4: When a slot opens and it is empty or has just finished a problem, and `ld_req` is high, `ld_take` pulses in that cycle. The slot then runs a first pass: `slot_first` is 1 and `slot_iter` is 0.
- R5: A problem's slot returns every P*(N+3) cycles. While live, `slot_iter` gives the number of iterations already issued for that problem.
- R6: A returning problem continues only if `fb_delta`*2^FRAC is greater than EPS2*`fb_delta0`, with EPS2 an unsigned fraction with FRAC=16 bits. Equality counts as converged.
- R7: When the test says converged, `done` pulses in the slot's first cycle with `done_conv`=1. `done_tag` gives the slot tag and `done_iters` the iterations completed.
- R8: A problem that still has to continue after MAX_ITER iterations ends with `done`=1 and `done_conv`=0. When convergence and the limit fall together, convergence wins.
- R9: `ld_req` has no effect at the opening of a slot whose problem continues: `ld_take` stays low.
- R10: During reset and right after it, tag and cycle are 0, every slot is empty, and `done`, `ld_take` and `slot_op` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | A new problem is waiting to be loaded |
| fb_delta0 | input | W | Initial residual energy of the returning problem |
| fb_delta | input | W | Latest residual energy of the returning problem |
| ld_take | output | 1 | The waiting problem is accepted into the current slot |
| slot_start | output | 1 | First cycle of a slot |
| slot_tag | output | $clog2(P) | Tag of the current slot and of its problem |
| slot_op | output | 3 | Product-unit operation: 0 idle, 1 row, 2 direction dot, 3 residual dot, 4 initial energy |
| row_idx | output | $clog2(N) | Matrix row streamed in a row cycle |
| slot_first | output | 1 | Current slot runs a problem's first pass (initialise x=0, d=r=b) |
| slot_iter | output | $clog2(MAX_ITER+1) | Iterations already issued for the slot's problem |
| done | output | 1 | A problem has terminated |
| done_tag | output | $clog2(P) | Tag of the terminated problem |
| done_conv | output | 1 | 1 if it converged, 0 if it hit the iteration limit |
| done_iters | output | $clog2(MAX_ITER+1) | Iterations the terminated problem completed |
| pad_len | output | $clog2(N+4) | Padding cycles that round the loop up to whole slots |

## Verification
Termination of one problem and admission of the next can land on the same opening cycle of the same tag. The bench holds `ld_req` high while problems remain, so later problems are forced onto tags whose owners are finishing in that cycle. It then checks that `done`, `done_tag` and `ld_take` all appear together, and that the slot goes on to run a first pass for the newcomer. The convergence decision is judged at the exact threshold (equal, so it stops), just above it, and in the case where it coincides with the iteration limit. A scoreboard predicts each problem's termination cycle as its load cycle plus iterations times P*(N+3).

// File: rtl/rr_seq_pkg.sv
package rr_seq_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_ROW  = 3'd1,
    OP_DQ   = 3'd2,
    OP_RR   = 3'd3,
    OP_INIT = 3'd4
  } slot_op_e;

  // Unpadded loop latency of one iteration, in cycles.
  function automatic int loop_base(int n, int lin, int lg, int fix);
    return lin * n + lg * $clog2(n) + fix;
  endfunction

  // Slots in the padded loop: number of problems in flight.
  function automatic int loop_slots(int n, int lin, int lg, int fix);
    int s;
    s = n + 3;
    return (loop_base(n, lin, lg, fix) + s - 1) / s;
  endfunction

  // Extra delay that rounds the loop up to whole slots.
  function automatic int loop_pad(int n, int lin, int lg, int fix);
    return loop_slots(n, lin, lg, fix) * (n + 3) - loop_base(n, lin, lg, fix);
  endfunction

  // Continue while new energy exceeds eps^2 times initial energy.
  function automatic logic keep_going(input logic [31:0] d, input logic [31:0] d0,
                                      input logic [31:0] e2, input int frac);
    logic [63:0] lhs;
    logic [63:0] rhs;
    lhs = {32'b0, d} << frac;
    rhs = {32'b0, e2} * {32'b0, d0};
    return lhs > rhs;
  endfunction

endpackage

// File: rtl/rr_slot_timer.sv
module rr_slot_timer #(
  parameter int SLOT  = 7,
  parameter int NSLOT = 33,
  localparam int CW = $clog2(SLOT),
  localparam int TW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cyc,
  output logic [TW-1:0] tag,
  output logic          at_start
);

  localparam logic [CW-1:0] LAST_CYC = CW'(SLOT - 1);
  localparam logic [TW-1:0] LAST_TAG = TW'(NSLOT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0;
      tag <= '0;
    end else if (cyc == LAST_CYC) begin
      cyc <= '0;
      tag <= (tag == LAST_TAG) ? '0 : tag + TW'(1);
    end else begin
      cyc <= cyc + CW'(1);
    end
  end

  assign at_start = (cyc == '0);

endmodule

// File: rtl/rr_slot_table.sv
module rr_slot_table #(
  parameter int NSLOT = 33,
  parameter int IW    = 3,
  localparam int TW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tag,
  input  logic          wr_en,
  input  logic          wr_busy,
  input  logic [IW-1:0] wr_iters,
  output logic          rd_busy,
  output logic [IW-1:0] rd_iters
);

  logic [NSLOT-1:0] busy_vec;
  logic [IW-1:0]    iters_mem [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_vec[i]  <= 1'b0;
        iters_mem[i] <= '0;
      end else if (wr_en && (tag == TW'(i))) begin
        busy_vec[i]  <= wr_busy;
        iters_mem[i] <= wr_iters;
      end
    end
  end

  assign rd_busy  = busy_vec[tag];
  assign rd_iters = iters_mem[tag];

endmodule

// File: rtl/rr_op_decode.sv
module rr_op_decode
  import rr_seq_pkg::*;
#(
  parameter int N = 4,
  localparam int CW = $clog2(N + 3),
  localparam int RW = $clog2(N)
) (
  input  logic [CW-1:0] cyc,
  input  logic          live,
  input  logic          first,
  output slot_op_e      op,
  output logic [RW-1:0] row
);

  always_comb begin
    op  = OP_IDLE;
    row = '0;
    if (live) begin
      if (cyc < CW'(N)) begin
        op  = OP_ROW;
        row = cyc[RW-1:0];
      end else if (cyc == CW'(N)) begin
        op = OP_DQ;
      end else if (cyc == CW'(N + 1)) begin
        op = OP_RR;
      end else if (first) begin
        op = OP_INIT;
      end
    end
  end

endmodule

// File: rtl/rr_iter_sequencer.sv
module rr_iter_sequencer
  import rr_seq_pkg::*;
#(
  parameter int N        = 4,
  parameter int MAX_ITER = 6,
  parameter int W        = 16,
  parameter int EPS2     = 256,
  parameter int FRAC     = 16,
  parameter int LAT_LIN  = 7,
  parameter int LAT_LOG  = 36,
  parameter int LAT_FIX  = 127,
  localparam int S   = N + 3,
  localparam int P   = loop_slots(N, LAT_LIN, LAT_LOG, LAT_FIX),
  localparam int PAD = loop_pad(N, LAT_LIN, LAT_LOG, LAT_FIX),
  localparam int CW  = $clog2(S),
  localparam int TW  = $clog2(P),
  localparam int IW  = $clog2(MAX_ITER + 1),
  localparam int RW  = $clog2(N),
  localparam int PLW = $clog2(S + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_req,
  input  logic [W-1:0]   fb_delta0,
  input  logic [W-1:0]   fb_delta,
  output logic           ld_take,
  output logic           slot_start,
  output logic [TW-1:0]  slot_tag,
  output logic [2:0]     slot_op,
  output logic [RW-1:0]  row_idx,
  output logic           slot_first,
  output logic [IW-1:0]  slot_iter,
  output logic           done,
  output logic [TW-1:0]  done_tag,
  output logic           done_conv,
  output logic [IW-1:0]  done_iters,
  output logic [PLW-1:0] pad_len
);

  logic [CW-1:0] cyc;
  logic [TW-1:0] tag;
  logic          at_start;
  logic          rd_busy;
  logic [IW-1:0] rd_iters;

  // Named events for the checker.
  logic          go;
  logic          at_max;
  logic          visit_busy;
  logic          fin_conv;
  logic          fin_max;
  logic          cont;
  logic          slot_free;
  logic          take;
  logic          slot_live;
  logic          live_first;

  logic          cur_live;
  logic          cur_first;
  logic [IW-1:0] cur_iter;
  logic          tbl_wr;
  logic          tbl_busy;
  logic [IW-1:0] tbl_iters;
  slot_op_e      op_sel;

  rr_slot_timer #(.SLOT(S), .NSLOT(P)) u_timer (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .tag(tag), .at_start(at_start)
  );

  rr_slot_table #(.NSLOT(P), .IW(IW)) u_table (
    .clk(clk), .rst_n(rst_n), .tag(tag),
    .wr_en(tbl_wr), .wr_busy(tbl_busy), .wr_iters(tbl_iters),
    .rd_busy(rd_busy), .rd_iters(rd_iters)
  );

  // Termination decision for the problem returning to this slot.
  assign go         = keep_going(32'(fb_delta), 32'(fb_delta0), 32'(EPS2), FRAC);
  assign at_max     = (rd_iters == IW'(MAX_ITER));
  assign visit_busy = at_start & rd_busy;
  assign fin_conv   = visit_busy & ~go;
  assign fin_max    = visit_busy & go & at_max;
  assign cont       = visit_busy & go & ~at_max;
  assign slot_free  = at_start & (~rd_busy | fin_conv | fin_max);
  assign take       = slot_free & ld_req;

  assign tbl_wr    = at_start & (fin_conv | fin_max | take | cont);
  assign tbl_busy  = take | cont;
  assign tbl_iters = take ? IW'(1) : (cont ? rd_iters + IW'(1) : rd_iters);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_live  <= 1'b0;
      cur_first <= 1'b0;
      cur_iter  <= '0;
    end else if (at_start) begin
      cur_live  <= take | cont;
      cur_first <= take;
      cur_iter  <= take ? '0 : rd_iters;
    end
  end

  assign slot_live  = at_start ? (take | cont) : cur_live;
  assign live_first = slot_live & (at_start ? take : cur_first);

  rr_op_decode #(.N(N)) u_dec (
    .cyc(cyc), .live(slot_live), .first(live_first), .op(op_sel), .row(row_idx)
  );

  assign ld_take    = take;
  assign slot_start = at_start;
  assign slot_tag   = tag;
  assign slot_op    = op_sel;
  assign slot_first = live_first;
  assign slot_iter  = !slot_live ? '0 : (at_start ? (take ? '0 : rd_iters) : cur_iter);
  assign done       = fin_conv | fin_max;
  assign done_tag   = tag;
  assign done_conv  = fin_conv;
  assign done_iters = rd_iters;
  assign pad_len    = PLW'(PAD);

endmodule

// File: rtl/rr_iter_sequencer_chk.sv
module rr_iter_sequencer_chk
  import rr_seq_pkg::*;
#(
  parameter int N        = 4,
  parameter int MAX_ITER = 6,
  parameter int LAT_LIN  = 7,
  parameter int LAT_LOG  = 36,
  parameter int LAT_FIX  = 127,
  localparam int S  = N + 3,
  localparam int P  = loop_slots(N, LAT_LIN, LAT_LOG, LAT_FIX),
  localparam int CW = $clog2(S),
  localparam int TW = $clog2(P),
  localparam int IW = $clog2(MAX_ITER + 1),
  localparam int RW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slot_start,
  input logic [TW-1:0] slot_tag,
  input logic [2:0]    slot_op,
  input logic [RW-1:0] row_idx,
  input logic          ld_take,
  input logic          slot_first,
  input logic [IW-1:0] slot_iter,
  input logic          done,
  input logic          done_conv,
  input logic [IW-1:0] done_iters,
  input logic          visit_busy,
  input logic          slot_live,
  input logic          fin_conv,
  input logic          fin_max
);

  logic [CW-1:0] ph;
  logic [TW-1:0] last_tag;
  logic [TW-1:0] want_tag;
  logic          seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= '0;
      last_tag <= '0;
      seen     <= 1'b0;
    end else begin
      ph <= (ph == CW'(S - 1)) ? '0 : ph + CW'(1);
      if (slot_start) begin
        last_tag <= slot_tag;
        seen     <= 1'b1;
      end
    end
  end

  assign want_tag = (last_tag == TW'(P - 1)) ? '0 : last_tag + TW'(1);

  AST_SLOT_OPEN:   assert property (@(posedge clk) disable iff (!rst_n) slot_start |-> ph == '0);  // R1
  AST_SLOT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) ph == '0 |-> slot_start);  // R1
  AST_TAG_STEP:    assert property (@(posedge clk) disable iff (!rst_n) (slot_start && seen) |-> slot_tag == want_tag);  // R1
  AST_EMPTY_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) !slot_live |-> slot_op == 3'd0);  // R2
  AST_ROW_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) slot_op == 3'd1 |-> row_idx == ph[RW-1:0]);  // R2
  AST_LOAD_FIRST:  assert property (@(posedge clk) disable iff (!rst_n) ld_take |-> (slot_start && slot_first && slot_iter == '0));  // R4
  AST_ITER_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) slot_live |-> slot_iter < IW'(MAX_ITER));  // R5
  AST_DONE_OPEN:   assert property (@(posedge clk) disable iff (!rst_n) done |-> slot_start);  // R7
  AST_ONE_CAUSE:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0({fin_conv, fin_max}));  // R7
  AST_LIMIT_EXIT:  assert property (@(posedge clk) disable iff (!rst_n) (done && !done_conv) |-> done_iters == IW'(MAX_ITER));  // R8
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (visit_busy && !done) |-> !ld_take);  // R9
  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (!done && !ld_take));  // R10

endmodule

bind rr_iter_sequencer rr_iter_sequencer_chk #(
  .N(N), .MAX_ITER(MAX_ITER), .LAT_LIN(LAT_LIN), .LAT_LOG(LAT_LOG), .LAT_FIX(LAT_FIX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .slot_tag(slot_tag),
  .slot_op(slot_op), .row_idx(row_idx), .ld_take(ld_take), .slot_first(slot_first),
  .slot_iter(slot_iter), .done(done), .done_conv(done_conv), .done_iters(done_iters),
  .visit_busy(visit_busy), .slot_live(slot_live), .fin_conv(fin_conv), .fin_max(fin_max)
);

// File: tb/rr_iter_sequencer_test.sv
module rr_iter_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int N        = 4;
  localparam int MAX_ITER = 6;
  localparam int W        = 16;
  localparam int S        = N + 3;
  localparam int LOGN     = $clog2(N);
  localparam int BASE     = 7 * N + 36 * LOGN + 127;
  localparam int P        = (BASE + S - 1) / S;
  localparam int LOOP     = P * S;
  localparam int TW       = $clog2(P);
  localparam int IW       = $clog2(MAX_ITER + 1);
  localparam int RW       = $clog2(N);
  localparam int PLW      = $clog2(S + 1);
  localparam int NPROB    = 40;
  localparam int LIMIT    = 20000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           ld_req;
  logic [W-1:0]   fb_delta0;
  logic [W-1:0]   fb_delta;
  logic           ld_take, slot_start, slot_first, done, done_conv;
  logic [TW-1:0]  slot_tag, done_tag;
  logic [2:0]     slot_op;
  logic [RW-1:0]  row_idx;
  logic [IW-1:0]  slot_iter, done_iters;
  logic [PLW-1:0] pad_len;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rr_iter_sequencer uut (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .fb_delta0(fb_delta0), .fb_delta(fb_delta),
    .ld_take(ld_take), .slot_start(slot_start), .slot_tag(slot_tag), .slot_op(slot_op),
    .row_idx(row_idx), .slot_first(slot_first), .slot_iter(slot_iter), .done(done),
    .done_tag(done_tag), .done_conv(done_conv), .done_iters(done_iters), .pad_len(pad_len)
  );

  int n_chk = 0, n_fail = 0, n_done = 0;
  int m_busy [P];
  int m_iters[P];
  int m_prob [P];
  int next_prob, bc;
  bit load_on;

  typedef struct { int tag; int due; int iters; bit conv; } exp_t;
  exp_t sb[$];

  // Pending model update decided in a slot's opening cycle.
  bit p_take, p_cont, p_done, p_conv;
  int p_tag;
  bit s_live, s_first;
  int s_iter;

  assign ld_req = load_on && (next_prob < NPROB);

  // Datapath stub: energies returned for the problem now owning the slot.
  // Problem j converges once j%8 iterations are done (0 or 7: never within limit).
  int fi, fc;
  always_comb begin
    fi = int'(slot_tag) % P;
    fc = m_prob[fi] % 8;
    fb_delta0 = 16'd2560;
    fb_delta  = 16'd11;
    if (m_busy[fi] != 0 && fc != 0 && m_iters[fi] >= fc)
      fb_delta = (m_prob[fi] % 2 == 1) ? 16'd10 : 16'd3;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_expect(int tag, int prob, int at);
    int c, k;
    bit cv;
    c  = prob % 8;
    cv = (c >= 1 && c <= MAX_ITER);
    k  = cv ? c : MAX_ITER;
    sb.push_back('{tag: tag, due: at + k * LOOP, iters: k, conv: cv});
  endtask

  task automatic step_check();
    int ec, et, k, eop, c;
    ec = bc % S;
    et = (bc / S) % P;
    chk(slot_start == (ec == 0), "R1", "slot_start", int'(slot_start), int'(ec == 0));
    chk(int'(slot_tag) == et, "R1", "slot_tag", int'(slot_tag), et);
    p_take = 0; p_cont = 0; p_done = 0; p_conv = 0; p_tag = et;
    if (ec == 0) begin
      k = m_iters[et];
      c = m_prob[et] % 8;
      if (m_busy[et] != 0) begin
        if (c != 0 && k >= c) begin p_done = 1; p_conv = 1; end
        else if (k == MAX_ITER) p_done = 1;
        else p_cont = 1;
      end
      p_take  = (m_busy[et] == 0 || p_done) && ld_req;
      s_live  = p_take || p_cont;
      s_first = p_take;
      s_iter  = p_take ? 0 : k;
      if (m_busy[et] != 0 && !p_done)
        chk(ld_take == 1'b0, "R9", "ld_take on continuing slot", int'(ld_take), 0);
      else
        chk(ld_take == p_take, "R4", "ld_take", int'(ld_take), int'(p_take));
      if (p_cont)
        chk(done == 1'b0, "R6", "done above threshold", int'(done), 0);
      else
        chk(done == p_done, "R7", "done", int'(done), int'(p_done));
      if (p_done && done) begin
        if (p_conv && (m_prob[et] % 2 == 1))
          chk(done_conv == 1'b1, "R6", "converged at equal threshold", int'(done_conv), 1);
        else
          chk(done_conv == p_conv, p_conv ? "R7" : "R8", "done_conv", int'(done_conv), int'(p_conv));
        chk(int'(done_iters) == k, "R7", "done_iters", int'(done_iters), k);
        chk(int'(done_tag) == et, "R7", "done_tag", int'(done_tag), et);
      end
    end
    eop = 0;
    if (s_live) begin
      if (ec < N) eop = 1;
      else if (ec == N) eop = 2;
      else if (ec == N + 1) eop = 3;
      else eop = s_first ? 4 : 0;
    end
    chk(int'(slot_op) == eop, "R2", "slot_op", int'(slot_op), eop);
    if (eop == 1) chk(int'(row_idx) == ec, "R2", "row_idx", int'(row_idx), ec);
    chk(slot_first == (s_live && s_first), "R4", "slot_first", int'(slot_first), int'(s_live && s_first));
    if (s_live) chk(int'(slot_iter) == s_iter, "R5", "slot_iter", int'(slot_iter), s_iter);
  endtask

  task automatic apply();
    if (p_take) begin
      m_busy[p_tag]  = 1;
      m_iters[p_tag] = 1;
      m_prob[p_tag]  = next_prob;
      push_expect(p_tag, next_prob, bc);
      next_prob++;
    end else if (p_cont) begin
      m_iters[p_tag]++;
    end else if (p_done) begin
      m_busy[p_tag] = 0;
    end
  endtask

  // Scoreboard monitor: each termination is matched against its prediction.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n === 1'b1 && done === 1'b1) begin
        int hit;
        hit = -1;
        for (int i = 0; i < sb.size(); i++)
          if (hit < 0 && sb[i].tag == int'(done_tag)) hit = i;
        n_done++;
        if (hit < 0) begin
          chk(0, "R7", "unexpected done for tag", int'(done_tag), -1);
        end else begin
          chk(sb[hit].due == bc, "R5", "termination cycle", bc, sb[hit].due);
          chk(sb[hit].iters == int'(done_iters), "R8", "iterations at exit", int'(done_iters), sb[hit].iters);
          chk(sb[hit].conv == done_conv, "R8", "exit kind", int'(done_conv), int'(sb[hit].conv));
          sb.delete(hit);
        end
      end
    end
  end

  initial begin
    int tail;
    rst_n = 1'b0;
    load_on = 0;
    next_prob = 0;
    bc = 0;
    s_live = 0; s_first = 0; s_iter = 0;
    for (int i = 0; i < P; i++) begin m_busy[i] = 0; m_iters[i] = 0; m_prob[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(int'(slot_tag) == 0, "R10", "tag in reset", int'(slot_tag), 0);
    chk(slot_start == 1'b1, "R10", "cycle 0 in reset", int'(slot_start), 1);
    chk(done == 1'b0, "R10", "done in reset", int'(done), 0);
    chk(ld_take == 1'b0, "R10", "ld_take in reset", int'(ld_take), 0);
    chk(slot_op == 3'd0, "R10", "op in reset", int'(slot_op), 0);
    chk(int'(pad_len) == LOOP - BASE, "R3", "pad_len", int'(pad_len), LOOP - BASE);
    rst_n = 1'b1;
    #1;
    tail = 0;
    while (bc < LIMIT && tail < LOOP) begin
      step_check();
      @(posedge clk);
      #1;
      apply();
      bc++;
      load_on = (bc >= 2 * S);
      @(negedge clk);
      #1;
      if (n_done >= NPROB) tail++;
    end
    if (bc >= LIMIT) chk(0, "R1", "watchdog expired at cycle", bc, LIMIT);
    chk(n_done == NPROB, "R7", "problems terminated", n_done, NPROB);
    chk(sb.size() == 0, "R7", "predictions left over", sb.size(), 0);
    chk(next_prob == NPROB, "R4", "problems loaded", next_prob, NPROB);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule